// File: doc/BRIEF.md
# Flash Program/Erase Control Register with Key Lock

This block is the software-facing register front end of a flash program/erase engine. It holds the operation mode bits (program enable, single-page erase, whole-array erase), a 7-bit page selector, a burst-programming mode bit, a start trigger, two interrupt enables and a bit that inverts the reported security state of the memory. When software requests a start, the block checks that an erase mode is selected before it launches the engine. An invalid request is rejected and flagged as a sequence error instead.

The control register is protected by a lock bit that is set out of reset. Software may set it at any time but can only clear it by writing two key words in order to a key register. A wrong key or a wrong order disables unlocking until the next reset. A down-counter stands in for the erase engine. It reports busy for a parameterised number of cycles, and when busy drops it raises an end-of-operation flag and clears the start bit. The status flags clear when 1 is written to them. The single interrupt output combines the end-of-operation flag and the operation-error flag, each gated by its own enable.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x8000_0000 (only the lock bit, bit 31, set). The status register reads 0, and busy and irq are 0.
- R2: While locked, a write to the control register (offset 0x4) changes nothing. Readback, busy and the status flags stay as they were.
- R3: Writing 0x45670123 and then 0x CDEF89AB to the key register (offset 0x0) as two consecutive key writes clears the lock. Reads of the key register return 0.
- R4: A key write with any other value, or the two keys in the wrong order, leaves the lock set. All later key writes are then ignored until reset, including a correct sequence.
- R5: When the block is unlocked and idle, a control write stores its fields and reads them back at these positions: bit 0 program enable, bit 1 page erase, bit 2 mass erase, bits 10:4 page number, bit 12 burst mode, bit 20 end-of-operation interrupt enable, bit 21 error interrupt enable, bit 24 invert.
- R6: A start (bit 16) written together with page erase or mass erase sets busy from the next cycle, and busy stays set for BUSY_CYC cycles. The start bit reads 1 exactly while busy is 1. When busy falls, the end-of-operation flag (status bit 1) is set.
- R7: A start written with both erase bits clear launches nothing and leaves the start bit at 0. It sets the sequence-error flag (status bit 2).
- R8: A control write with start set while busy is rejected. It sets the operation-error flag (status bit 3) and leaves the control register unchanged.
- R9: Status bits 1 to 3 clear when 1 is written to them at offset 0x8. Writing 0 to a bit leaves it unchanged. Status bit 0 reads busy.
- R10: irq equals (end-of-operation flag AND its enable) OR (operation-error flag AND the error enable).
- R11: An unlocked control write with bit 31 set locks the register again. A fresh correct key sequence then unlocks it.
- R12: secure_view equals the SECURE_DEFAULT parameter XOR the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset: 0x0 key, 0x4 control, 0x8 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| busy | output | 1 | Engine busy |
| irq | output | 1 | Combined interrupt request |
| secure_view | output | 1 | Reported security state of the memory |

## Verification
Most faults in the lock sequencer show up at the control register readback on the very next access. A sequencer that never enters its dead state lets a later correct key pair unlock the register. A sequencer that skips the second key leaves control readback at zero after a single key write. A faulty busy counter changes the number of cycles busy stays high, and the start bit then disagrees with busy in the cycle where they split. A wrong rule for setting or clearing a flag shows up in the status word read directly after the triggering write, and in irq during the same cycle.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam int DATA_W = 32;
    localparam int PAGE_W = 7;

    localparam int OFF_KEY  = 'h0;
    localparam int OFF_CTRL = 'h4;
    localparam int OFF_STAT = 'h8;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'hCDEF_89AB;

    localparam int B_PROG   = 0;
    localparam int B_PER    = 1;
    localparam int B_MER    = 2;
    localparam int B_PAGE   = 4;
    localparam int B_BURST  = 12;
    localparam int B_START  = 16;
    localparam int B_EOPIE  = 20;
    localparam int B_ERRIE  = 21;
    localparam int B_INV    = 24;
    localparam int B_LOCK   = 31;

    localparam int S_BUSY = 0;
    localparam int S_EOP  = 1;
    localparam int S_SEQ  = 2;
    localparam int S_OPE  = 3;

    typedef struct packed {
        logic              prog;
        logic              per;
        logic              mer;
        logic [PAGE_W-1:0] page;
        logic              burst;
        logic              start;
        logic              eop_ie;
        logic              err_ie;
        logic              inv;
        logic              lock;
    } ctrl_t;

    typedef struct packed {
        logic eop;
        logic seq;
        logic ope;
    } flags_t;

    typedef enum logic [1:0] {
        LK_WAIT1 = 2'd0,
        LK_WAIT2 = 2'd1,
        LK_DEAD  = 2'd2
    } lock_st_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_PROG]            = c.prog;
        v[B_PER]             = c.per;
        v[B_MER]             = c.mer;
        v[B_PAGE +: PAGE_W]  = c.page;
        v[B_BURST]           = c.burst;
        v[B_START]           = c.start;
        v[B_EOPIE]           = c.eop_ie;
        v[B_ERRIE]           = c.err_ie;
        v[B_INV]             = c.inv;
        v[B_LOCK]            = c.lock;
        return v;
    endfunction

    function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] v);
        ctrl_t c;
        c.prog   = v[B_PROG];
        c.per    = v[B_PER];
        c.mer    = v[B_MER];
        c.page   = v[B_PAGE +: PAGE_W];
        c.burst  = v[B_BURST];
        c.start  = v[B_START];
        c.eop_ie = v[B_EOPIE];
        c.err_ie = v[B_ERRIE];
        c.inv    = v[B_INV];
        c.lock   = v[B_LOCK];
        return c;
    endfunction

endpackage

// File: rtl/fctl_lock_unit.sv
module fctl_lock_unit
    import flash_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    input  logic              relock,
    output logic              locked
);

    lock_st_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LK_WAIT1;
            locked <= 1'b1;
        end else if (relock) begin
            locked <= 1'b1;
            st_q   <= LK_WAIT1;
        end else if (key_wr && locked) begin
            case (st_q)
                LK_WAIT1: st_q <= (key_data == KEY_FIRST) ? LK_WAIT2 : LK_DEAD;
                LK_WAIT2: begin
                    if (key_data == KEY_SECOND) begin
                        locked <= 1'b0;
                        st_q   <= LK_WAIT1;
                    end else begin
                        st_q   <= LK_DEAD;
                    end
                end
                default: st_q <= LK_DEAD;
            endcase
        end
    end

    // R4: a failed sequence keeps the register locked
    p_dead_locked_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == LK_DEAD) |-> locked);

    // R3: the lock only drops right after the second key word
    p_unlock_on_second_key_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(key_wr && st_q == LK_WAIT2 && key_data == KEY_SECOND));

endmodule

// File: rtl/fctl_engine.sv
module fctl_engine #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (launch && !busy) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(BUSY_CYC - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);

    // R6: busy only rises after a launch request
    p_busy_after_launch_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(launch));

endmodule

// File: rtl/fctl_status.sv
module fctl_status
    import flash_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_f,
    input  flags_t clr_f,
    input  logic   eop_ie,
    input  logic   err_ie,
    output flags_t flags,
    output logic   irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.eop <= set_f.eop | (flags.eop & ~clr_f.eop);
            flags.seq <= set_f.seq | (flags.seq & ~clr_f.seq);
            flags.ope <= set_f.ope | (flags.ope & ~clr_f.ope);
        end
    end

    assign irq = (flags.eop & eop_ie) | (flags.ope & err_ie);

    // R7: a rejected start always shows the sequence error
    p_seq_flag_r7: assert property (@(posedge clk) disable iff (rst)
        set_f.seq |=> flags.seq);

    // R9: without a set or a clear, flags hold
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (set_f == '0 && clr_f == '0) |=> $stable(flags));

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int BUSY_CYC       = 16,
    parameter int ADDR_W         = 4,
    parameter bit SECURE_DEFAULT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy,
    output logic              irq,
    output logic              secure_view
);

    logic   sel_key, sel_ctrl, sel_stat;
    logic   wr_ctrl, allow, start_req, start_ok, launch, done, locked, relock;
    ctrl_t  w, ctrl_q, ctrl_rd;
    flags_t set_f, clr_f, flags;
    logic [DATA_W-1:0] ctrl_vec, stat_vec;

    assign sel_key  = (addr == ADDR_W'(OFF_KEY));
    assign sel_ctrl = (addr == ADDR_W'(OFF_CTRL));
    assign sel_stat = (addr == ADDR_W'(OFF_STAT));

    assign w         = unpack_ctrl(wdata);
    assign wr_ctrl   = wr_en && sel_ctrl;
    assign allow     = wr_ctrl && !locked && !busy;
    assign start_req = allow && w.start;
    assign start_ok  = start_req && (w.per || w.mer);
    assign launch    = start_ok;
    assign relock    = allow && w.lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (allow) begin
                ctrl_q       <= w;
                ctrl_q.start <= start_ok;
                ctrl_q.lock  <= 1'b0;
            end
            if (done) ctrl_q.start <= 1'b0;
        end
    end

    fctl_lock_unit u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_en && sel_key),
        .key_data (wdata),
        .relock   (relock),
        .locked   (locked)
    );

    fctl_engine #(.BUSY_CYC(BUSY_CYC)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    always_comb begin
        set_f.eop = done;
        set_f.seq = start_req && !start_ok;
        set_f.ope = wr_ctrl && !locked && busy && w.start;
        clr_f     = '0;
        if (wr_en && sel_stat) begin
            clr_f.eop = wdata[S_EOP];
            clr_f.seq = wdata[S_SEQ];
            clr_f.ope = wdata[S_OPE];
        end
    end

    fctl_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .set_f  (set_f),
        .clr_f  (clr_f),
        .eop_ie (ctrl_q.eop_ie),
        .err_ie (ctrl_q.err_ie),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        ctrl_rd      = ctrl_q;
        ctrl_rd.lock = locked;
        ctrl_vec     = pack_ctrl(ctrl_rd);
        stat_vec         = '0;
        stat_vec[S_BUSY] = busy;
        stat_vec[S_EOP]  = flags.eop;
        stat_vec[S_SEQ]  = flags.seq;
        stat_vec[S_OPE]  = flags.ope;
        if (sel_ctrl)      rdata = ctrl_vec;
        else if (sel_stat) rdata = stat_vec;
        else               rdata = '0;
    end

    assign secure_view = SECURE_DEFAULT ^ ctrl_q.inv;

    // R6: start bit and engine busy move together
    p_start_tracks_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.start == busy);

    // R2: a locked control write leaves the register untouched
    p_locked_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_ctrl) |=> $stable(ctrl_q));

    // R6: falling busy leaves the end-of-operation flag set
    p_eop_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flags.eop);

    // R8: start while busy raises the operation error
    p_busy_start_err_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !locked && busy && w.start) |=> flags.ope);

endmodule

// File: tb/sim_flash_ctl_regs.sv
`timescale 1ns/1ps
module sim_flash_ctl_regs;

    localparam int B = 6;
    localparam logic [31:0] K1 = 32'h4567_0123;
    localparam logic [31:0] K2 = 32'hCDEF_89AB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy, irq, secure_view;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    flash_ctl_regs #(.BUSY_CYC(B), .ADDR_W(4), .SECURE_DEFAULT(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .irq(irq), .secure_view(secure_view)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d exp=<100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin
        logic [31:0] v;
        int cnt;
        do_reset();

        // R1 reset state
        rd(4'h4, v); chk("R1 ctrl", v, 32'h8000_0000);
        rd(4'h8, v); chk("R1 stat", v, 32'h0);
        chk("R1 busy/irq", {30'b0, busy, irq}, 32'h0);

        // R2 locked write ignored
        wr(4'h4, 32'h0001_0002);
        rd(4'h4, v); chk("R2 ctrl", v, 32'h8000_0000);
        rd(4'h8, v); chk("R2 stat", v, 32'h0);

        // R4 wrong value then right keys
        wr(4'h0, 32'h1234_5678);
        wr(4'h0, K1); wr(4'h0, K2);
        rd(4'h4, v); chk("R4 wrong value", v, 32'h8000_0000);
        do_reset();
        // R4 wrong order
        wr(4'h0, K2); wr(4'h0, K1);
        wr(4'h0, K1); wr(4'h0, K2);
        rd(4'h4, v); chk("R4 wrong order", v, 32'h8000_0000);
        do_reset();
        // R4 correct first, wrong second
        wr(4'h0, K1); wr(4'h0, K1);
        wr(4'h0, K1); wr(4'h0, K2);
        rd(4'h4, v); chk("R4 bad second", v, 32'h8000_0000);
        do_reset();

        // R3 unlock
        wr(4'h0, K1);
        rd(4'h4, v); chk("R3 half key still locked", v, 32'h8000_0000);
        wr(4'h0, K2);
        rd(4'h4, v); chk("R3 unlocked", v, 32'h0);
        rd(4'h0, v); chk("R3 key reads zero", v, 32'h0);

        // R5 / R12 sweep over all pages
        for (int p = 0; p < 128; p++) begin
            logic [31:0] d;
            d = (32'(p) << 4) | 32'(p & 1) | (32'((p >> 1) & 1) << 12) | (32'((p >> 2) & 1) << 24);
            wr(4'h4, d);
            rd(4'h4, v); chk("R5 fields", v, d);
            chk("R12 secure_view", {31'b0, secure_view}, {31'b0, 1'b1 ^ d[24]});
        end

        // R7 invalid start
        wr(4'h4, 32'h0001_0001);
        rd(4'h8, v); chk("R7 seq flag", v, 32'h4);
        rd(4'h4, v); chk("R7 start stays 0", v, 32'h1);

        // R9 write-one-to-clear
        wr(4'h8, 32'h0);
        rd(4'h8, v); chk("R9 zero write", v, 32'h4);
        wr(4'h8, 32'h4);
        rd(4'h8, v); chk("R9 clear", v, 32'h0);

        // R6 valid page erase
        wr(4'h4, 32'h0011_0052);
        addr = 4'h4;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            #1;
            chk("R6 start==busy", {31'b0, rdata[16]}, {31'b0, busy});
            if (!busy) break;
            cnt++;
            @(negedge clk);
        end
        chk("R6 busy length", 32'(cnt), 32'(B));
        rd(4'h8, v); chk("R6 eop", v, 32'h2);
        rd(4'h4, v); chk("R6 ctrl after", v, 32'h0010_0052);
        chk("R10 irq eop", {31'b0, irq}, 32'h1);
        wr(4'h8, 32'h2);

        // R8 start while busy
        wr(4'h4, 32'h0001_0004);
        chk("R6 mass erase busy", {31'b0, busy}, 32'h1);
        wr(4'h4, 32'h0031_00F2);
        rd(4'h4, v); chk("R8 ctrl unchanged", v, 32'h0001_0004);
        rd(4'h8, v); chk("R8 ope flag", v, 32'h9);
        chk("R10 irq ie off", {31'b0, irq}, 32'h0);
        wait_idle();
        rd(4'h8, v); chk("R8 after done", v, 32'hA);

        // R10 sweep of enables against flag states
        for (int s = 0; s < 3; s++) begin
            logic fe, fo;
            fe = (s == 0);
            fo = (s < 2);
            for (int ie = 0; ie < 4; ie++) begin
                wr(4'h4, 32'(ie) << 20);
                #1;
                chk("R10 irq", {31'b0, irq},
                    {31'b0, (fe & ie[0]) | (fo & ie[1])});
            end
            if (s == 0) wr(4'h8, 32'h2);
            if (s == 1) wr(4'h8, 32'h8);
        end

        // R11 relock then unlock again
        wr(4'h4, 32'h8000_0000);
        rd(4'h4, v); chk("R11 relocked", v, 32'h8000_0000);
        wr(4'h4, 32'h0000_0002);
        rd(4'h4, v); chk("R11 write ignored", v, 32'h8000_0000);
        wr(4'h0, K1); wr(4'h0, K2);
        rd(4'h4, v); chk("R11 unlocked again", v, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule